// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core. It watches eleven request sources: two timer overflows, two serial channels and seven external lines. Three of the external lines are each fed by a group of peripheral events. Each source has a request flag. The flag is captured on the machine-cycle strobe whether or not the source is enabled. The flags are then masked by per-source enables and by one global enable, and ranked by a four-level priority.

At every instruction boundary the controller decides whether the core must be diverted. When it must, it raises a one-cycle call pulse together with the fixed vector address of the winning source. The controller keeps one in-service bit per priority level, so a request only pre-empts a handler of strictly lower level. A return-from-interrupt ends the handler at the highest level in service. Acknowledgement is suppressed at the boundary that closes a return-from-interrupt, and at the boundary that closes an instruction which wrote an enable or priority register. The earliest acknowledgement is therefore one instruction later. Software reaches all enables, priorities and flags through a byte-wide special-register port.

Top module: `ic_ctrl`

## Requirements
- R1: After reset every register reads 0, `call_o` is 0 and `vec_o` is 0.
- R2: A source's request flag is set on a clock where `mc_tick_i` is high and its condition input is high. This holds whatever the enables are. A condition without `mc_tick_i` sets nothing.
- R3: Flag of source 6 is the OR of `wcol_i[1:0]` and `spi_i`. Flag of source 10 is the OR of `xfer_busy_i`, `sec_tick_i` and `wdog_warn_i`. Flag of source 8 is set when `lock_i` differs from its value at the previous tick (both edges; the remembered value is 0 after reset).
- R4: A source is acknowledged only if its enable bit is 1 and bit 7 of register 0xA8 (global enable) is 1. Bit 6 of 0xA8 is stored but enables nothing.
- R5: Enable layout. In 0xA8, bits 0..4 enable sources 0 (ext0), 1 (timer 0), 2 (ext1), 3 (timer 1) and 4 (serial 0). Bit 0 of 0x9A enables source 5 (serial 1). Bits 1..5 of 0xB8 enable sources 6, 7, 8, 9 and 10.
- R6: Source i belongs to group i mod 6. Its level is {bit g of 0xB9, bit g of 0xA9}, where g is the group. The highest level wins, and a tie goes to the lowest source index.
- R7: When a request is taken at a clock with `bound_i` high, `call_o` is high for the next cycle only and `vec_o` = 3 + 8·index. There is no call without `bound_i`.
- R8: A request is not taken while its level is equal to or lower than the highest level in service. Taking a request marks its level in service.
- R9: `bound_i` together with `reti_i` clears the highest in-service level.
- R10: No request is taken at a boundary with `reti_i` high. No request is taken at a boundary where 0xA8, 0xB8, 0x9A, 0xA9 or 0xB9 was written in that cycle or at any point since the previous boundary.
- R11: Taking a request clears its flag, except for the shared sources 6, 8 and 10, whose flags remain set.
- R12: A write to 0xC0 loads flags 0..7, and a write to 0xC1 loads flags 8..10 from bits 0..2. A condition captured in the same cycle overrides the written 0.
- R13: Reads return the stored bits, with unused bits as 0: 0xA8 bit 5, 0xB8 bits 7, 6 and 0, 0x9A bits 7..1, 0xA9 and 0xB9 bits 7..6, 0xC1 bits 7..3. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick_i | input | 1 | Machine-cycle strobe; condition inputs are sampled when high |
| sfr_addr_i | input | 8 | Special-register address |
| sfr_wr_i | input | 1 | Write strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data for the current address |
| ext0_i | input | 1 | External request 0 |
| ext1_i | input | 1 | External request 1 |
| tmr0_ovf_i | input | 1 | Timer 0 overflow |
| tmr1_ovf_i | input | 1 | Timer 1 overflow |
| ser0_i | input | 1 | Serial channel 0 event |
| ser1_i | input | 1 | Serial channel 1 event |
| ext3_i | input | 1 | External request 3 |
| ext5_i | input | 1 | External request 5 |
| wcol_i | input | 2 | Two write-collision events (shared line 2) |
| spi_i | input | 1 | SPI event (shared line 2) |
| lock_i | input | 1 | Lock indicator level (line 4, both edges) |
| xfer_busy_i | input | 1 | Transfer-busy event (shared line 6) |
| sec_tick_i | input | 1 | One-second tick (shared line 6) |
| wdog_warn_i | input | 1 | Watchdog warning (shared line 6) |
| bound_i | input | 1 | The current instruction ends this cycle |
| reti_i | input | 1 | The ending instruction is a return-from-interrupt |
| call_o | output | 1 | One-cycle request to force a call |
| vec_o | output | 8 | Vector address of the call |

## Verification
Directed sequences try the decision logic with different request patterns. A single pending source shows that masking and vector arithmetic are right. Two sources at one level, with one then raised, separate the index tie-break from the level ranking. A lower or equal request arriving during service, followed by returns, shows nesting and level unwinding. Writes and returns placed exactly on a boundary show the one-instruction holdoff, and shared-line and lock-edge events show which flags survive an acknowledge. A long random phase with interleaved ticks, boundaries, returns and register writes is compared on every cycle with a behavioural model, which catches ordering errors that no directed case reaches.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int NSRC  = 11;
  localparam int NGRP  = 6;
  localparam int NLVL  = 4;
  localparam int LVL_W = $clog2(NLVL);
  localparam int IDX_W = $clog2(NSRC);
  localparam int SFR_W = 8;
  localparam int HI_W  = NSRC - SFR_W;

  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [SFR_W-1:0] byte_t;

  localparam int S_EXT0 = 0;
  localparam int S_TMR0 = 1;
  localparam int S_EXT1 = 2;
  localparam int S_TMR1 = 3;
  localparam int S_SER0 = 4;
  localparam int S_SER1 = 5;
  localparam int S_EXT2 = 6;
  localparam int S_EXT3 = 7;
  localparam int S_EXT4 = 8;
  localparam int S_EXT5 = 9;
  localparam int S_EXT6 = 10;

  localparam byte_t A_EN_MAIN = 8'hA8;
  localparam byte_t A_EN_EXT  = 8'hB8;
  localparam byte_t A_EN_AUX  = 8'h9A;
  localparam byte_t A_PRI_LO  = 8'hA9;
  localparam byte_t A_PRI_HI  = 8'hB9;
  localparam byte_t A_REQ_LO  = 8'hC0;
  localparam byte_t A_REQ_HI  = 8'hC1;

  // main enable: bit 5 has no storage
  localparam byte_t MAIN_KEEP = 8'hDF;

  // flags of lines fed by several events survive an acknowledge
  localparam src_vec_t SHARED =
    src_vec_t'((1 << S_EXT2) | (1 << S_EXT4) | (1 << S_EXT6));

  function automatic int grp_of(input int i);
    return i % NGRP;
  endfunction
endpackage

// File: rtl/ic_req_flags.sv
module ic_req_flags
  import ic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ext0_i,
  input  logic       ext1_i,
  input  logic       tmr0_i,
  input  logic       tmr1_i,
  input  logic       ser0_i,
  input  logic       ser1_i,
  input  logic       ext3_i,
  input  logic       ext5_i,
  input  logic [1:0] wcol_i,
  input  logic       spi_i,
  input  logic       lock_i,
  input  logic       xfer_i,
  input  logic       sec_i,
  input  logic       wdog_i,
  input  logic       wr_lo_i,
  input  logic       wr_hi_i,
  input  byte_t      wdata_i,
  input  src_vec_t   ack_clr_i,
  output src_vec_t   flags_o
);
  src_vec_t flags_q, flags_d, cond;
  logic     lock_q, lock_d;

  // condition of each source at this sample
  always_comb begin
    cond         = '0;
    cond[S_EXT0] = ext0_i;
    cond[S_TMR0] = tmr0_i;
    cond[S_EXT1] = ext1_i;
    cond[S_TMR1] = tmr1_i;
    cond[S_SER0] = ser0_i;
    cond[S_SER1] = ser1_i;
    cond[S_EXT2] = (|wcol_i) | spi_i;
    cond[S_EXT3] = ext3_i;
    cond[S_EXT4] = lock_i ^ lock_q;
    cond[S_EXT5] = ext5_i;
    cond[S_EXT6] = xfer_i | sec_i | wdog_i;
  end

  // software load, then acknowledge clear, then capture (capture wins)
  always_comb begin
    flags_d = flags_q;
    if (wr_lo_i) flags_d[SFR_W-1:0] = wdata_i;
    if (wr_hi_i) flags_d[NSRC-1:SFR_W] = wdata_i[HI_W-1:0];
    flags_d = flags_d & ~ack_clr_i;
    if (tick_i) flags_d = flags_d | cond;
    lock_d = tick_i ? lock_i : lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      lock_q  <= lock_d;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/ic_sfr_regs.sv
module ic_sfr_regs
  import ic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  byte_t           addr_i,
  input  logic            wr_i,
  input  byte_t           wdata_i,
  input  src_vec_t        flags_i,
  output src_vec_t        en_o,
  output logic            glob_o,
  output logic [NGRP-1:0] plo_o,
  output logic [NGRP-1:0] phi_o,
  output byte_t           rdata_o,
  output logic            req_wr_lo_o,
  output logic            req_wr_hi_o,
  output logic            cfg_wr_o
);
  localparam int EXT_N = 5;

  byte_t            main_q, main_d;
  logic [EXT_N-1:0] ext_q, ext_d;
  logic             aux_q, aux_d;
  logic [NGRP-1:0]  plo_q, plo_d, phi_q, phi_d;
  logic             hit_main, hit_ext, hit_aux, hit_plo, hit_phi;

  assign hit_main    = wr_i && (addr_i == A_EN_MAIN);
  assign hit_ext     = wr_i && (addr_i == A_EN_EXT);
  assign hit_aux     = wr_i && (addr_i == A_EN_AUX);
  assign hit_plo     = wr_i && (addr_i == A_PRI_LO);
  assign hit_phi     = wr_i && (addr_i == A_PRI_HI);
  assign req_wr_lo_o = wr_i && (addr_i == A_REQ_LO);
  assign req_wr_hi_o = wr_i && (addr_i == A_REQ_HI);
  assign cfg_wr_o    = hit_main | hit_ext | hit_aux | hit_plo | hit_phi;

  always_comb begin
    main_d = main_q;
    ext_d  = ext_q;
    aux_d  = aux_q;
    plo_d  = plo_q;
    phi_d  = phi_q;
    if (hit_main) main_d = wdata_i & MAIN_KEEP;
    if (hit_ext)  ext_d  = wdata_i[EXT_N:1];
    if (hit_aux)  aux_d  = wdata_i[0];
    if (hit_plo)  plo_d  = wdata_i[NGRP-1:0];
    if (hit_phi)  phi_d  = wdata_i[NGRP-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      ext_q  <= '0;
      aux_q  <= 1'b0;
      plo_q  <= '0;
      phi_q  <= '0;
    end else begin
      main_q <= main_d;
      ext_q  <= ext_d;
      aux_q  <= aux_d;
      plo_q  <= plo_d;
      phi_q  <= phi_d;
    end
  end

  always_comb begin
    en_o         = '0;
    en_o[S_EXT0] = main_q[0];
    en_o[S_TMR0] = main_q[1];
    en_o[S_EXT1] = main_q[2];
    en_o[S_TMR1] = main_q[3];
    en_o[S_SER0] = main_q[4];
    en_o[S_SER1] = aux_q;
    en_o[S_EXT2] = ext_q[0];
    en_o[S_EXT3] = ext_q[1];
    en_o[S_EXT4] = ext_q[2];
    en_o[S_EXT5] = ext_q[3];
    en_o[S_EXT6] = ext_q[4];
  end

  assign glob_o = main_q[SFR_W-1];
  assign plo_o  = plo_q;
  assign phi_o  = phi_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_EN_MAIN: rdata_o = main_q;
      A_EN_EXT:  rdata_o[EXT_N:1] = ext_q;
      A_EN_AUX:  rdata_o[0] = aux_q;
      A_PRI_LO:  rdata_o[NGRP-1:0] = plo_q;
      A_PRI_HI:  rdata_o[NGRP-1:0] = phi_q;
      A_REQ_LO:  rdata_o = flags_i[SFR_W-1:0];
      A_REQ_HI:  rdata_o[HI_W-1:0] = flags_i[NSRC-1:SFR_W];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter
  import ic_pkg::*;
(
  input  src_vec_t        flags_i,
  input  src_vec_t        en_i,
  input  logic            glob_i,
  input  logic [NGRP-1:0] plo_i,
  input  logic [NGRP-1:0] phi_i,
  output logic            valid_o,
  output idx_t            idx_o,
  output lvl_t            lvl_o
);
  lvl_t     lvl_of [NSRC];
  src_vec_t req;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign lvl_of[i] = {phi_i[grp_of(i)], plo_i[grp_of(i)]};
  end

  assign req = flags_i & en_i & {NSRC{glob_i}};

  // scan in polling order; only a strictly higher level displaces
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!valid_o || (lvl_of[i] > lvl_o))) begin
        valid_o = 1'b1;
        idx_o   = idx_t'(i);
        lvl_o   = lvl_of[i];
      end
    end
  end
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick_i,
  input  logic [7:0]       sfr_addr_i,
  input  logic             sfr_wr_i,
  input  logic [7:0]       sfr_wdata_i,
  output logic [7:0]       sfr_rdata_o,
  input  logic             ext0_i,
  input  logic             ext1_i,
  input  logic             tmr0_ovf_i,
  input  logic             tmr1_ovf_i,
  input  logic             ser0_i,
  input  logic             ser1_i,
  input  logic             ext3_i,
  input  logic             ext5_i,
  input  logic [1:0]       wcol_i,
  input  logic             spi_i,
  input  logic             lock_i,
  input  logic             xfer_busy_i,
  input  logic             sec_tick_i,
  input  logic             wdog_warn_i,
  input  logic             bound_i,
  input  logic             reti_i,
  output logic             call_o,
  output logic [VEC_W-1:0] vec_o
);
  src_vec_t        flags, en, ack_clr;
  logic            glob_en, req_wr_lo, req_wr_hi, cfg_wr;
  logic [NGRP-1:0] plo, phi;
  logic            cand_valid;
  idx_t            cand_idx;
  lvl_t            cand_lvl;

  logic [NLVL-1:0] isr_q, isr_d;
  logic            hold_q, hold_d;
  logic            call_q, call_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic            top_valid, blocked, above, take;
  lvl_t            top_lvl;

  ic_sfr_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (sfr_addr_i),
    .wr_i        (sfr_wr_i),
    .wdata_i     (sfr_wdata_i),
    .flags_i     (flags),
    .en_o        (en),
    .glob_o      (glob_en),
    .plo_o       (plo),
    .phi_o       (phi),
    .rdata_o     (sfr_rdata_o),
    .req_wr_lo_o (req_wr_lo),
    .req_wr_hi_o (req_wr_hi),
    .cfg_wr_o    (cfg_wr)
  );

  ic_req_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (mc_tick_i),
    .ext0_i    (ext0_i),
    .ext1_i    (ext1_i),
    .tmr0_i    (tmr0_ovf_i),
    .tmr1_i    (tmr1_ovf_i),
    .ser0_i    (ser0_i),
    .ser1_i    (ser1_i),
    .ext3_i    (ext3_i),
    .ext5_i    (ext5_i),
    .wcol_i    (wcol_i),
    .spi_i     (spi_i),
    .lock_i    (lock_i),
    .xfer_i    (xfer_busy_i),
    .sec_i     (sec_tick_i),
    .wdog_i    (wdog_warn_i),
    .wr_lo_i   (req_wr_lo),
    .wr_hi_i   (req_wr_hi),
    .wdata_i   (sfr_wdata_i),
    .ack_clr_i (ack_clr),
    .flags_o   (flags)
  );

  ic_arbiter u_arb (
    .flags_i (flags),
    .en_i    (en),
    .glob_i  (glob_en),
    .plo_i   (plo),
    .phi_i   (phi),
    .valid_o (cand_valid),
    .idx_o   (cand_idx),
    .lvl_o   (cand_lvl)
  );

  // highest level currently in service
  always_comb begin
    top_valid = 1'b0;
    top_lvl   = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_q[l]) begin
        top_valid = 1'b1;
        top_lvl   = lvl_t'(l);
      end
    end
  end

  assign blocked = hold_q | cfg_wr | reti_i;
  assign above   = !top_valid || (cand_lvl > top_lvl);
  assign take    = bound_i && !blocked && cand_valid && above;
  assign ack_clr = take ? ((src_vec_t'(1) << cand_idx) & ~SHARED) : '0;

  always_comb begin
    isr_d = isr_q;
    if (take)
      isr_d[cand_lvl] = 1'b1;
    else if (bound_i && reti_i && top_valid)
      isr_d[top_lvl] = 1'b0;
    hold_d = bound_i ? 1'b0 : (hold_q | cfg_wr);
    call_d = take;
    vec_d  = VEC_W'(VEC_BASE + VEC_STRIDE * int'(cand_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      hold_q <= 1'b0;
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      isr_q  <= isr_d;
      hold_q <= hold_d;
      call_q <= call_d;
      if (take) vec_q <= vec_d;
    end
  end

  assign call_o = call_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/ic_ctrl_chk.sv
module ic_ctrl_chk
  import ic_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bound_i,
  input logic             reti_i,
  input logic             sfr_wr_i,
  input logic [7:0]       sfr_addr_i,
  input logic             call_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [NLVL-1:0]  isr,
  input logic             glob_en
);
  logic cfg_hit;
  assign cfg_hit = sfr_wr_i && ((sfr_addr_i == A_EN_MAIN) || (sfr_addr_i == A_EN_EXT) ||
                   (sfr_addr_i == A_EN_AUX) || (sfr_addr_i == A_PRI_LO) ||
                   (sfr_addr_i == A_PRI_HI));

  a_r7_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !bound_i |=> !call_o);

  a_r7_vector_form: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> ((int'(vec_o) >= VEC_BASE) &&
                ((int'(vec_o) - VEC_BASE) % VEC_STRIDE == 0) &&
                ((int'(vec_o) - VEC_BASE) / VEC_STRIDE < NSRC)));

  a_r10_reti_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_i && reti_i) |=> !call_o);

  a_r10_cfg_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_i && cfg_hit) |=> !call_o);

  a_r4_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_i && !glob_en) |=> !call_o);

  a_r9_reti_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_i && reti_i && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr))));

  a_r8_service_grows: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> ($countones(isr) == $countones($past(isr)) + 1));
endmodule

bind ic_ctrl ic_ctrl_chk #(
  .VEC_W      (VEC_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bound_i    (bound_i),
  .reti_i     (reti_i),
  .sfr_wr_i   (sfr_wr_i),
  .sfr_addr_i (sfr_addr_i),
  .call_o     (call_o),
  .vec_o      (vec_o),
  .isr        (isr_q),
  .glob_en    (glob_en)
);

// File: tb/ic_ctrl_bench.sv
module ic_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, wr = 0, bnd = 0, reti = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       e0 = 0, e1 = 0, t0 = 0, t1 = 0, s0 = 0, s1 = 0, e3 = 0, e5 = 0;
  logic [1:0] wcol = 0;
  logic       spi = 0, lock = 0, xfer = 0, sec = 0, wdog = 0;
  logic [7:0] rdata, vec;
  logic       call;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ic_ctrl u_ic_ctrl (
    .clk(clk), .rst_n(rst_n), .mc_tick_i(tick),
    .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_wdata_i(wdata), .sfr_rdata_o(rdata),
    .ext0_i(e0), .ext1_i(e1), .tmr0_ovf_i(t0), .tmr1_ovf_i(t1),
    .ser0_i(s0), .ser1_i(s1), .ext3_i(e3), .ext5_i(e5),
    .wcol_i(wcol), .spi_i(spi), .lock_i(lock),
    .xfer_busy_i(xfer), .sec_tick_i(sec), .wdog_warn_i(wdog),
    .bound_i(bnd), .reti_i(reti), .call_o(call), .vec_o(vec)
  );

  // ---------------- behavioural reference ----------------
  int m_main, m_ext, m_aux, m_plo, m_phi, m_flags, m_isr, m_hold, m_lock, m_call, m_vec;

  function automatic int m_en(input int i);
    case (i)
      0: return (m_main >> 0) & 1;
      1: return (m_main >> 1) & 1;
      2: return (m_main >> 2) & 1;
      3: return (m_main >> 3) & 1;
      4: return (m_main >> 4) & 1;
      5: return m_aux & 1;
      default: return (m_ext >> (i - 5)) & 1;
    endcase
  endfunction

  function automatic int m_lvl(input int i);
    int g = i % 6;
    return 2 * ((m_phi >> g) & 1) + ((m_plo >> g) & 1);
  endfunction

  function automatic int m_read(input logic [7:0] a);
    case (a)
      8'hA8: return m_main;
      8'hB8: return m_ext;
      8'h9A: return m_aux;
      8'hA9: return m_plo;
      8'hB9: return m_phi;
      8'hC0: return m_flags & 8'hFF;
      8'hC1: return (m_flags >> 8) & 7;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int best = -1, top = -1, cond = 0;
    bit cfgw, take;
    for (int lv = 3; lv >= 0 && best < 0; lv--)
      for (int i = 0; i < 11 && best < 0; i++)
        if (((m_flags >> i) & 1) && m_en(i) && ((m_main >> 7) & 1) && m_lvl(i) == lv) best = i;
    for (int l = 0; l < 4; l++) if ((m_isr >> l) & 1) top = l;
    cfgw = wr && (addr == 8'hA8 || addr == 8'hB8 || addr == 8'h9A || addr == 8'hA9 || addr == 8'hB9);
    take = bnd && !(m_hold || cfgw || reti) && best >= 0 && m_lvl(best) > top;
    if (wr && addr == 8'hC0) m_flags = (m_flags & ~8'hFF) | wdata;
    if (wr && addr == 8'hC1) m_flags = (m_flags & 8'hFF) | ((wdata & 7) << 8);
    if (take && best != 6 && best != 8 && best != 10) m_flags &= ~(1 << best);
    if (tick) begin
      cond = e0 | (t0 << 1) | (e1 << 2) | (t1 << 3) | (s0 << 4) | (s1 << 5)
           | (((|wcol) | spi) << 6) | (e3 << 7) | ((lock != m_lock) << 8)
           | (e5 << 9) | ((xfer | sec | wdog) << 10);
      m_flags |= cond;
      m_lock = lock;
    end
    if (take) m_isr |= (1 << m_lvl(best));
    else if (bnd && reti && top >= 0) m_isr &= ~(1 << top);
    m_hold = bnd ? 0 : (m_hold | cfgw);
    if (wr && addr == 8'hA8) m_main = wdata & 8'hDF;
    if (wr && addr == 8'hB8) m_ext = wdata & 8'h3E;
    if (wr && addr == 8'h9A) m_aux = wdata & 1;
    if (wr && addr == 8'hA9) m_plo = wdata & 8'h3F;
    if (wr && addr == 8'hB9) m_phi = wdata & 8'h3F;
    m_call = take;
    if (take) m_vec = 3 + 8 * best;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_main = 0; m_ext = 0; m_aux = 0; m_plo = 0; m_phi = 0; m_flags = 0;
      m_isr = 0; m_hold = 0; m_lock = 0; m_call = 0; m_vec = 0;
    end else model_step();
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R7 call_o vs model", call, m_call);
      check("R7 vec_o vs model", vec, m_vec);
      check("R13 rdata vs model", rdata, m_read(addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clr();
    tick = 0; wr = 0; bnd = 0; reti = 0;
    e0 = 0; e1 = 0; t0 = 0; t1 = 0; s0 = 0; s1 = 0; e3 = 0; e5 = 0;
    wcol = 0; spi = 0; xfer = 0; sec = 0; wdog = 0;
  endtask

  task automatic go();
    @(negedge clk); #3;
    clr();
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input bit b);
    addr = a; wdata = d; wr = 1; bnd = b;
    go();
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic boundary(input bit r);
    bnd = 1; reti = r;
    go();
  endtask

  task automatic do_reset();
    rst_n = 0; clr();
    repeat (2) @(negedge clk);
    #3 rst_n = 1;
  endtask

  function automatic logic [7:0] pick_addr(input int k);
    case (k % 8)
      0: return 8'hA8; 1: return 8'hB8; 2: return 8'h9A; 3: return 8'hA9;
      4: return 8'hB9; 5: return 8'hC0; 6: return 8'hC1; default: return 8'h55;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 call after reset", call, 0);
    check("R1 vec after reset", vec, 0);
    rd(8'hA8, 0, "R1 0xA8"); rd(8'hB8, 0, "R1 0xB8"); rd(8'h9A, 0, "R1 0x9A");
    rd(8'hA9, 0, "R1 0xA9"); rd(8'hB9, 0, "R1 0xB9"); rd(8'hC0, 0, "R1 0xC0");
    rd(8'hC1, 0, "R1 0xC1");

    // R5 / R13 layout and unused bits
    wr_reg(8'hA8, 8'hFF, 0); rd(8'hA8, 8'hDF, "R13 0xA8 bit5");
    wr_reg(8'hB8, 8'hFF, 0); rd(8'hB8, 8'h3E, "R5 0xB8 bits");
    wr_reg(8'h9A, 8'hFF, 0); rd(8'h9A, 8'h01, "R5 0x9A bit0");
    wr_reg(8'hA9, 8'hFF, 0); rd(8'hA9, 8'h3F, "R13 0xA9");
    rd(8'h77, 0, "R13 unmapped");
    wr_reg(8'hA8, 0, 0); wr_reg(8'hB8, 0, 0); wr_reg(8'h9A, 0, 0); wr_reg(8'hA9, 0, 0);

    // R2 capture only on tick, regardless of enable
    e1 = 1; go(); rd(8'hC0, 8'h00, "R2 no tick");
    e1 = 1; tick = 1; go(); rd(8'hC0, 8'h04, "R2 tick capture");
    boundary(0); boundary(0); check("R4 disabled no call", call, 0);

    // R10 write on the boundary, then R7 call
    wr_reg(8'hA8, 8'h84, 1); check("R10 write holdoff", call, 0);
    boundary(0); check("R7 call pulse", call, 1); check("R7 vector ext1", vec, 8'h13);
    rd(8'hC0, 8'h00, "R11 dedicated cleared");
    go(); check("R7 single cycle", call, 0);

    // R8 equal level blocked, R9 return frees it
    e0 = 1; tick = 1; go();
    wr_reg(8'hA8, 8'h85, 0);
    boundary(0); check("R10 earlier write holdoff", call, 0);
    boundary(0); check("R8 equal level blocked", call, 0);
    boundary(1); check("R10 reti holdoff", call, 0);
    boundary(0); check("R9 after return", call, 1); check("R7 vector ext0", vec, 8'h03);
    boundary(1);

    // R6 tie-break and level ranking
    wr_reg(8'hA8, 8'h98, 0); wr_reg(8'hC0, 8'h18, 0);
    boundary(0);
    boundary(0); check("R6 tie call", call, 1); check("R6 tie lowest index", vec, 8'h1B);
    boundary(0); check("R8 same level pending", call, 0);
    wr_reg(8'hA9, 8'h10, 0);
    boundary(0);
    boundary(0); check("R6 raised level call", call, 1); check("R6 raised vec", vec, 8'h23);
    boundary(1); boundary(1);
    boundary(0); check("R9 all served", call, 0);
    rd(8'hC0, 0, "R11 both cleared");
    wr_reg(8'hA9, 0, 0);

    // R3 shared lines, R11 shared flags stay
    wr_reg(8'hA8, 8'h80, 0); wr_reg(8'hB8, 8'h22, 0);
    spi = 1; tick = 1; go(); rd(8'hC0, 8'h40, "R3 spi on line 2");
    boundary(0);
    boundary(0); check("R3 shared call", call, 1); check("R7 vector line 2", vec, 8'h33);
    rd(8'hC0, 8'h40, "R11 shared flag kept");
    wr_reg(8'hC0, 0, 0); rd(8'hC0, 0, "R12 software clear");
    boundary(1);
    sec = 1; tick = 1; go(); rd(8'hC1, 8'h04, "R3 tick on line 6");
    wr_reg(8'hC1, 0, 0);
    lock = 1; tick = 1; go(); rd(8'hC1, 8'h01, "R3 lock rise");
    wr_reg(8'hC1, 0, 0);
    tick = 1; go(); rd(8'hC1, 8'h00, "R3 lock steady");
    lock = 0; tick = 1; go(); rd(8'hC1, 8'h01, "R3 lock fall");
    wr_reg(8'hC1, 0, 0);

    // R12 capture beats same-cycle write
    addr = 8'hC0; wdata = 0; wr = 1; e0 = 1; tick = 1; go();
    rd(8'hC0, 8'h01, "R12 capture wins");
    wr_reg(8'hC0, 0, 0);

    // R4 bit 6 is not a global enable
    wr_reg(8'hA8, 8'h41, 0); wr_reg(8'hB8, 0, 0);
    e0 = 1; tick = 1; go();
    boundary(0); boundary(0); boundary(0);
    check("R4 bit6 enables nothing", call, 0);
    rd(8'hC0, 8'h01, "R4 flag still pending");

    // random phase against the model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      tick = ($urandom % 3) == 0;
      e0 = ($urandom % 8) == 0; e1 = ($urandom % 8) == 0;
      t0 = ($urandom % 8) == 0; t1 = ($urandom % 8) == 0;
      s0 = ($urandom % 8) == 0; s1 = ($urandom % 8) == 0;
      e3 = ($urandom % 8) == 0; e5 = ($urandom % 8) == 0;
      wcol = (($urandom % 10) == 0) ? 2'($urandom) : 2'b00;
      spi = ($urandom % 12) == 0; xfer = ($urandom % 12) == 0;
      sec = ($urandom % 12) == 0; wdog = ($urandom % 12) == 0;
      if (($urandom % 16) == 0) lock = ~lock;
      bnd = ($urandom % 3) == 0;
      reti = bnd && (($urandom % 4) == 0);
      addr = pick_addr($urandom);
      wr = ($urandom % 6) == 0;
      wdata = 8'($urandom);
      go();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule